// File: doc/BRIEF.md
# Vector Lane Insert Unit

This unit executes one form of vector instruction: it copies a single lane of one 128-bit vector register into a single lane of another register. Every other bit of the destination stays as it was. The unit decodes a 32-bit instruction word that is qualified by a valid strobe. From two immediate fields it derives the element width and both lane indices. It then reads the source and destination registers from an internal bank of 32 registers and writes the merged value back on the next clock edge.

The element width comes from the position of the lowest set bit in the 5-bit immediate. Encodings whose low four immediate bits are all zero are reserved, and they raise an undefined-instruction pulse. If the SIMD-enable input is low, a trap pulse is raised instead of executing the instruction.

A fill port lets the surrounding core load register contents. The fill port shares the single write port, and an insert takes precedence over it. After each completed insert, the whole updated destination register is presented on the result outputs.

Top module: `vec_lane_insert`

## Requirements
- R1: An instruction word is accepted only when `instValid` is high, bits 31:21 equal 01101110000, bit 15 is 0 and bit 10 is 1. Any other word produces no `done`, no flag and no register change.
- R2: The destination register is bits 4:0, the source register is bits 9:5, the 4-bit source immediate is bits 14:11 and the 5-bit immediate is bits 20:16.
- R3: The lowest set bit of imm5[3:0] selects the element width: bit 0 gives 8 bits, bit 1 gives 16, bit 2 gives 32 and bit 3 gives 64.
- R4: When imm5[3:0] is zero, `undefFlag` pulses for one cycle, the cycle after acceptance. Nothing is written and `done` stays low.
- R5: The destination lane index is imm5 shifted right by (size code + 1).
- R6: The source lane index is imm4 shifted right by the size code. The imm4 bits below the size code have no effect.
- R7: Only the chosen destination lane changes. All other bits of the destination register keep their previous value.
- R8: When `simdEnable` is low and the encoding is not reserved, `trapFlag` pulses in the cycle after acceptance and nothing is written. A reserved encoding reports undefined even when `simdEnable` is low.
- R9: After reset, every register holds zero and all outputs are zero.
- R10: `done` pulses exactly one cycle after acceptance, whatever the data. In that cycle, `resultReg` and `resultData` show the destination register number and its full new value, and they hold until the next insert. Back-to-back inserts each complete.
- R11: When the source and destination register are the same, the lane is read from the value before the write.
- R12: A fill with `fillValid` high writes `fillData` into register `fillReg` at the next edge, unless an insert writes in that same cycle, in which case the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Qualifies `instWord` |
| instWord | input | 32 | Instruction word |
| simdEnable | input | 1 | Vector execution enabled |
| fillValid | input | 1 | Fill write request |
| fillReg | input | 5 | Fill target register |
| fillData | input | 128 | Fill value |
| done | output | 1 | Insert completed (one-cycle pulse) |
| undefFlag | output | 1 | Reserved encoding seen (one-cycle pulse) |
| trapFlag | output | 1 | Instruction trapped because vector execution is disabled (one-cycle pulse) |
| resultReg | output | 5 | Register written by the last insert |
| resultData | output | 128 | Full value written by the last insert |

## Verification
The bench tests each element width at lanes away from zero and sets the ignored low imm4 bits to one. A unit that decoded the indices from the wrong bit range would move data from or to the wrong lane. Reserved and disabled encodings are followed by an insert into the same register, so any stray write shows up in the full-register result. Their combination checks that undefined outranks trap. Same-register copies, fills that collide with inserts, and near-miss opcodes catch a unit that reads after writing, lets a fill win, or decodes too loosely.

// File: rtl/vli_pkg.sv
package vli_pkg;
  localparam int SIZE_W = 2;
  localparam int LANE_W = 4;
  localparam logic [10:0] OPCODE_HI = 11'b01101110000;

  typedef struct packed {
    logic              wrEn;
    logic [SIZE_W-1:0] sizeCode;
    logic [LANE_W-1:0] srcLane;
    logic [LANE_W-1:0] dstLane;
  } insStrobes_t;
endpackage

// File: rtl/vli_ctrl.sv
module vli_ctrl
  import vli_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic              simdEnable,
  output insStrobes_t       strobes,
  output logic [REG_AW-1:0] srcReg,
  output logic [REG_AW-1:0] dstReg,
  output logic              undefFlag,
  output logic              trapFlag
);
  logic       opcodeHit;
  logic       accepted;
  logic       reserved;
  logic [4:0] imm5;
  logic [3:0] imm4;
  logic [SIZE_W-1:0] sizeCode;

  assign imm5 = instWord[20:16];
  assign imm4 = instWord[14:11];
  assign opcodeHit = (instWord[31:21] == OPCODE_HI) && !instWord[15] && instWord[10];
  assign accepted = instValid && opcodeHit;
  assign dstReg = REG_AW'(instWord[4:0]);
  assign srcReg = REG_AW'(instWord[9:5]);

  // lowest set bit of imm5[3:0] picks the element width
  always_comb begin
    reserved = 1'b0;
    casez (imm5[3:0])
      4'b???1: sizeCode = 2'd0;
      4'b??10: sizeCode = 2'd1;
      4'b?100: sizeCode = 2'd2;
      4'b1000: sizeCode = 2'd3;
      default: begin
        sizeCode = 2'd0;
        reserved = 1'b1;
      end
    endcase
  end

  always_comb begin
    strobes.wrEn     = accepted && !reserved && simdEnable;
    strobes.sizeCode = sizeCode;
    strobes.dstLane  = LANE_W'(imm5 >> ({1'b0, sizeCode} + 3'd1));
    strobes.srcLane  = imm4 >> sizeCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      undefFlag <= 1'b0;
      trapFlag  <= 1'b0;
    end else begin
      undefFlag <= accepted && reserved;
      trapFlag  <= accepted && !reserved && !simdEnable;
    end
  end

  assert_reserved_undef_R4: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opcodeHit && imm5[3:0] == 4'd0) |=> (undefFlag && !trapFlag));

  assert_disabled_trap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opcodeHit && imm5[3:0] != 4'd0 && !simdEnable) |=> (trapFlag && !undefFlag));

  assert_foreign_word_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!(instValid && opcodeHit)) |=> (!undefFlag && !trapFlag));
endmodule

// File: rtl/vli_datapath.sv
module vli_datapath
  import vli_pkg::*;
#(
  parameter int VLEN     = 128,
  parameter int NUM_REGS = 32,
  parameter int REG_AW   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  insStrobes_t       strobes,
  input  logic [REG_AW-1:0] srcReg,
  input  logic [REG_AW-1:0] dstReg,
  input  logic              fillValid,
  input  logic [REG_AW-1:0] fillReg,
  input  logic [VLEN-1:0]   fillData,
  output logic              done,
  output logic [REG_AW-1:0] resultReg,
  output logic [VLEN-1:0]   resultData
);
  localparam int SH_W = $clog2(VLEN);

  logic [VLEN-1:0] bank [NUM_REGS];
  logic [VLEN-1:0] srcVal;
  logic [VLEN-1:0] dstVal;
  logic [VLEN-1:0] elemOnes;
  logic [VLEN-1:0] laneMask;
  logic [VLEN-1:0] srcElem;
  logic [VLEN-1:0] merged;
  logic [SH_W-1:0] srcShift;
  logic [SH_W-1:0] dstShift;

  // both reads see the bank before this cycle's write
  assign srcVal = bank[srcReg];
  assign dstVal = bank[dstReg];

  always_comb begin
    case (strobes.sizeCode)
      2'd0:    elemOnes = VLEN'({8{1'b1}});
      2'd1:    elemOnes = VLEN'({16{1'b1}});
      2'd2:    elemOnes = VLEN'({32{1'b1}});
      default: elemOnes = VLEN'({64{1'b1}});
    endcase
  end

  // fixed shifter path: same logic regardless of operand values
  always_comb begin
    srcShift = SH_W'({strobes.srcLane, 3'b000}) << strobes.sizeCode;
    dstShift = SH_W'({strobes.dstLane, 3'b000}) << strobes.sizeCode;
    laneMask = elemOnes << dstShift;
    srcElem  = (srcVal >> srcShift) & elemOnes;
    merged   = (dstVal & ~laneMask) | ((srcElem << dstShift) & laneMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
      done       <= 1'b0;
      resultReg  <= '0;
      resultData <= '0;
    end else begin
      done <= strobes.wrEn;
      if (strobes.wrEn) begin
        bank[dstReg] <= merged;
        resultReg    <= dstReg;
        resultData   <= merged;
      end else if (fillValid) begin
        bank[fillReg] <= fillData;
      end
    end
  end

  assert_lane_keep_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> (((resultData ^ $past(dstVal)) & ~$past(laneMask)) == '0));

  assert_lane_copy_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> (((resultData >> $past(dstShift)) & $past(elemOnes)) ==
                      (($past(srcVal) >> $past(srcShift)) & $past(elemOnes))));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrEn |=> (!done && $stable(resultData) && $stable(resultReg)));
endmodule

// File: rtl/vec_lane_insert.sv
module vec_lane_insert
  import vli_pkg::*;
#(
  parameter int VLEN     = 128,
  parameter int NUM_REGS = 32,
  parameter int REG_AW   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic              simdEnable,
  input  logic              fillValid,
  input  logic [REG_AW-1:0] fillReg,
  input  logic [VLEN-1:0]   fillData,
  output logic              done,
  output logic              undefFlag,
  output logic              trapFlag,
  output logic [REG_AW-1:0] resultReg,
  output logic [VLEN-1:0]   resultData
);
  insStrobes_t       strobes;
  logic [REG_AW-1:0] srcReg;
  logic [REG_AW-1:0] dstReg;

  vli_ctrl #(.REG_AW(REG_AW)) i_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .simdEnable(simdEnable), .strobes(strobes), .srcReg(srcReg), .dstReg(dstReg),
    .undefFlag(undefFlag), .trapFlag(trapFlag)
  );

  vli_datapath #(.VLEN(VLEN), .NUM_REGS(NUM_REGS), .REG_AW(REG_AW)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcReg(srcReg), .dstReg(dstReg),
    .fillValid(fillValid), .fillReg(fillReg), .fillData(fillData),
    .done(done), .resultReg(resultReg), .resultData(resultData)
  );

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, undefFlag, trapFlag}));
endmodule

// File: tb/test_vec_lane_insert.sv
module test_vec_lane_insert;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         instValid = 1'b0;
  logic [31:0]  instWord = '0;
  logic         simdEnable = 1'b1;
  logic         fillValid = 1'b0;
  logic [4:0]   fillReg = '0;
  logic [127:0] fillData = '0;
  logic         done, undefFlag, trapFlag;
  logic [4:0]   resultReg;
  logic [127:0] resultData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [127:0] model [32];
  logic [4:0]   expReg = '0;
  logic [127:0] expData = '0;

  always #4 clk = ~clk;

  vec_lane_insert i_vec_lane_insert (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .simdEnable(simdEnable), .fillValid(fillValid), .fillReg(fillReg),
    .fillData(fillData), .done(done), .undefFlag(undefFlag), .trapFlag(trapFlag),
    .resultReg(resultReg), .resultData(resultData)
  );

  function automatic logic [31:0] mkIns(input logic [4:0] rd, input logic [4:0] rn,
                                        input logic [4:0] imm5, input logic [3:0] imm4);
    return {11'b01101110000, imm5, 1'b0, imm4, 1'b1, rn, rd};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  // one clock of stimulus plus comparison against the reference model
  task automatic step(input bit v, input logic [31:0] w, input bit en, input bit fv,
                      input logic [4:0] fr, input logic [127:0] fd, input string tag);
    bit hit, eDone, eUndef, eTrap;
    int sz, esize, dl, sl;
    logic [127:0] nv;
    instValid = v; instWord = w; simdEnable = en;
    fillValid = fv; fillReg = fr; fillData = fd;
    hit = (w[31:21] == 11'b01101110000) && !w[15] && w[10];
    eDone = 0; eUndef = 0; eTrap = 0; nv = '0;
    if (v && hit) begin
      sz = -1;
      for (int k = 0; k < 4; k++) if (w[16+k] && sz < 0) sz = k;
      if (sz < 0) eUndef = 1;
      else if (!en) eTrap = 1;
      else begin
        esize = 8 << sz;
        dl = int'(w[20:16]) >> (sz + 1);
        sl = int'(w[14:11]) >> sz;
        nv = model[w[4:0]];
        for (int b = 0; b < esize; b++) nv[dl*esize + b] = model[w[9:5]][sl*esize + b];
        eDone = 1;
      end
    end
    if (eDone) begin
      model[w[4:0]] = nv;
      expReg = w[4:0];
      expData = nv;
    end else if (fv) model[fr] = fd;
    @(negedge clk);
    chk(done == eDone, tag, "done", 128'(done), 128'(eDone));
    chk(undefFlag == eUndef, tag, "undefFlag", 128'(undefFlag), 128'(eUndef));
    chk(trapFlag == eTrap, tag, "trapFlag", 128'(trapFlag), 128'(eTrap));
    chk(resultReg == expReg, tag, "resultReg", 128'(resultReg), 128'(expReg));
    chk(resultData == expData, tag, "resultData", resultData, expData);
    instValid = 0; fillValid = 0;
  endtask

  task automatic fill(input logic [4:0] r, input logic [127:0] d);
    step(0, '0, 1, 1, r, d, "R12");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    chk({done, undefFlag, trapFlag} == 3'b000, "R9", "flags", 128'({done, undefFlag, trapFlag}), 0);
    chk(resultData == '0, "R9", "resultData", resultData, '0);
    // reset contents: copy from an untouched register
    step(1, mkIns(5'd9, 5'd31, 5'b11000, 4'b1000), 1, 0, '0, '0, "R9");
    for (int i = 0; i < 8; i++) fill(5'(i), rnd128());
    // R3 R5 R6: each width, lanes off zero, ignored imm4 bits set
    step(1, mkIns(5'd1, 5'd2, 5'b00111, 4'd12), 1, 0, '0, '0, "R3");
    step(1, mkIns(5'd2, 5'd4, 5'b10110, 4'b0111), 1, 0, '0, '0, "R5");
    step(1, mkIns(5'd4, 5'd5, 5'b10100, 4'b0111), 1, 0, '0, '0, "R6");
    step(1, mkIns(5'd5, 5'd6, 5'b11000, 4'b0111), 1, 0, '0, '0, "R7");
    step(1, mkIns(5'd6, 5'd7, 5'b01000, 4'b1000), 1, 0, '0, '0, "R2");
    // R4: reserved, then reveal the register
    step(1, mkIns(5'd3, 5'd0, 5'b10000, 4'd0), 1, 0, '0, '0, "R4");
    step(1, mkIns(5'd3, 5'd0, 5'b00000, 4'd5), 1, 0, '0, '0, "R4");
    step(1, mkIns(5'd3, 5'd0, 5'b00001, 4'd0), 1, 0, '0, '0, "R4");
    // R8: trap, and undefined outranks trap
    step(1, mkIns(5'd1, 5'd2, 5'b00101, 4'd3), 0, 0, '0, '0, "R8");
    step(1, mkIns(5'd1, 5'd2, 5'b10000, 4'd3), 0, 0, '0, '0, "R8");
    step(1, mkIns(5'd1, 5'd7, 5'b11111, 4'd15), 1, 0, '0, '0, "R8");
    // R1: near-miss opcodes and invalid strobe
    step(1, mkIns(5'd1, 5'd2, 5'b00011, 4'd1) | 32'h0000_8000, 1, 0, '0, '0, "R1");
    step(1, mkIns(5'd1, 5'd2, 5'b00011, 4'd1) & ~32'h0000_0400, 1, 0, '0, '0, "R1");
    step(1, mkIns(5'd1, 5'd2, 5'b00011, 4'd1) ^ 32'h4000_0000, 1, 0, '0, '0, "R1");
    step(0, mkIns(5'd1, 5'd2, 5'b00011, 4'd1), 1, 0, '0, '0, "R1");
    step(1, mkIns(5'd1, 5'd1, 5'b11111, 4'd0), 1, 0, '0, '0, "R1");
    // R11: same register source and destination
    step(1, mkIns(5'd3, 5'd3, 5'b00001, 4'd15), 1, 0, '0, '0, "R11");
    step(1, mkIns(5'd3, 5'd3, 5'b11000, 4'b0000), 1, 0, '0, '0, "R11");
    // R12: fill collides with insert, then reveal
    step(1, mkIns(5'd4, 5'd0, 5'b00010, 4'd2), 1, 1, 5'd0, '1, "R12");
    step(1, mkIns(5'd8, 5'd0, 5'b11000, 4'b1000), 1, 0, '0, '0, "R12");
    // R10: back-to-back random traffic
    for (int n = 0; n < 400; n++) begin
      step($urandom % 4 != 0,
           mkIns(5'($urandom % 12), 5'($urandom % 12), 5'($urandom), 4'($urandom)),
           $urandom % 8 != 0, $urandom % 3 == 0, 5'($urandom % 12), rnd128(), "R10");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R10 got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule